// File: doc/BRIEF.md
# Correlator Accumulation Readout Status Tracker

This block sits between the per-channel correlation engines and the processor bus. Whenever a channel signals a dump, the block captures four signed accumulation results for that channel: tracking in-phase, tracking quadrature, prompt in-phase and prompt quadrature. It marks fresh data with a per-channel new-data flag. It raises an interrupt while any flag is set and the interrupt is enabled. A dump that lands on unconsumed data sets a sticky missed flag. The correlation arithmetic itself is done elsewhere.

Each channel owns an eight-word slot on a simple read/write bus. The slot holds a status word followed by the four accumulators, so software can fetch all five words in one burst. Reading the prompt quadrature word consumes the data. A global slot placed after the channel slots provides summaries of both flags, the interrupt enable and a write-one-to-clear port for the missed flags. Any channel that is deactivated has its flags dropped and ignores dumps.

Top module: `accum_readout`

## Requirements
- R1: After reset every flag, the interrupt enable, `irq` and `rd_data` are zero.
- R2: A dump on an active channel c captures the four inputs into slot c (base address c*8). The tracking in-phase value goes to offset 1, tracking quadrature to offset 2, prompt in-phase to offset 3 and prompt quadrature to offset 4. A later dump overwrites these words whether or not they were read.
- R3: A dump on an active channel sets its new-data flag. The flag reads as bit 0 of the status word at offset 0 and as bit c of the new-data summary at global address NUM_CH*8+0.
- R4: A read of offset 4 clears the channel's new-data flag. Reads of offsets 0 to 3 leave it set.
- R5: A dump while the new-data flag is already set, with no offset-4 read of that channel in the same cycle, sets the missed flag. The missed flag reads as status bit 1 and as bit c of the missed summary at NUM_CH*8+1.
- R6: The missed flag is sticky through reads. A write to NUM_CH*8+3 clears the missed flag of each channel whose data bit is 1 and leaves the others alone. A new missed event in the same cycle as the clearing write wins.
- R7: While `ch_active[c]` is low, both flags of channel c are held at zero and its dumps are ignored, so the accumulators keep their values.
- R8: If a dump and an offset-4 read of the same channel happen in the same cycle, the new-data flag stays set and no missed flag is raised. The read returns the value held before the dump.
- R9: `irq` is high exactly when bit 0 of the control register at NUM_CH*8+2 is set and at least one new-data flag is set. That bit is readable and writable.
- R10: Unused offsets 5 to 7 of a channel slot and global offsets 4 to 7 read zero. Writes to accumulator, status, summary or unused addresses have no effect.
- R11: Read data appears on `rd_data` at the clock edge that accepts the read and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ch_active | input | NUM_CH | Per-channel enable; low clears the flags and blocks dumps |
| dump | input | NUM_CH | Per-channel dump strobe, one cycle per dump |
| i_trk_in | input | NUM_CH*ACC_W | Tracking in-phase results, channel c at slice c |
| q_trk_in | input | NUM_CH*ACC_W | Tracking quadrature results |
| i_prm_in | input | NUM_CH*ACC_W | Prompt in-phase results |
| q_prm_in | input | NUM_CH*ACC_W | Prompt quadrature results |
| bus_sel | input | 1 | Bus access request for this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | ACC_W | Write data |
| rd_data | output | ACC_W | Registered read data |
| irq | output | 1 | Accumulation interrupt |

## Verification
The assertions assume that `dump` is a single-cycle strobe per channel. They also assume that a bus access lasts one cycle with `bus_sel` high and that only the global write port clears missed flags. The flag properties are stated per cycle, so they remain valid when dumps, reads and deactivations coincide. The bench drives every input at the falling clock edge and holds each dump or bus access for exactly one cycle. It provokes the coincident cases deliberately, by raising a dump and a read or a clearing write in the same cycle.

// File: rtl/accum_pkg.sv
package accum_pkg;
  localparam int unsigned SLOT_OFS_W = 3;
  localparam int unsigned LANES      = 4;

  typedef enum logic [SLOT_OFS_W-1:0] {
    OFS_STAT  = 3'd0,
    OFS_I_TRK = 3'd1,
    OFS_Q_TRK = 3'd2,
    OFS_I_PRM = 3'd3,
    OFS_Q_PRM = 3'd4
  } slot_ofs_e;

  typedef enum logic [SLOT_OFS_W-1:0] {
    GREG_NEW  = 3'd0,
    GREG_MISS = 3'd1,
    GREG_CTRL = 3'd2,
    GREG_MCLR = 3'd3
  } greg_e;
endpackage

// File: rtl/accum_chan.sv
module accum_chan
  import accum_pkg::*;
#(
  parameter int unsigned ACC_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        active,
  input  logic                        dump,
  input  logic [LANES-1:0][ACC_W-1:0] lane_in,
  input  logic                        clr_rd,
  input  logic                        miss_clr,
  output logic                        new_flag,
  output logic                        miss_flag,
  output logic [LANES-1:0][ACC_W-1:0] lane_q
);
  logic cap;
  logic new_q, new_d, miss_q, miss_d;

  assign cap = dump & active;

  always_comb begin
    new_d  = new_q;
    miss_d = miss_q;
    if (!active) begin
      new_d  = 1'b0;
      miss_d = 1'b0;
    end else begin
      if (cap)         new_d = 1'b1;
      else if (clr_rd) new_d = 1'b0;
      if (cap && new_q && !clr_rd) miss_d = 1'b1;
      else if (miss_clr)           miss_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      new_q  <= 1'b0;
      miss_q <= 1'b0;
    end else begin
      new_q  <= new_d;
      miss_q <= miss_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   lane_q <= '0;
    else if (cap) lane_q <= lane_in;
  end

  assign new_flag  = new_q;
  assign miss_flag = miss_q;
endmodule

// File: rtl/accum_decode.sv
module accum_decode
  import accum_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned SLOT_W = ADDR_W - SLOT_OFS_W,
  localparam int unsigned CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_sel,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic                  rd_req,
  output logic                  chan_hit,
  output logic                  glb_hit,
  output logic [CH_W-1:0]       ch_idx,
  output logic [SLOT_OFS_W-1:0] ofs,
  output logic [NUM_CH-1:0]     clr_rd,
  output logic [NUM_CH-1:0]     miss_clr,
  output logic                  irq_en
);
  localparam logic [SLOT_W-1:0] GLB_SLOT = SLOT_W'(NUM_CH);

  logic [SLOT_W-1:0] slot;
  logic              wr_req;
  logic              irq_en_d;

  assign slot     = bus_addr[ADDR_W-1:SLOT_OFS_W];
  assign ofs      = bus_addr[SLOT_OFS_W-1:0];
  assign ch_idx   = CH_W'(slot);
  assign chan_hit = (slot < GLB_SLOT);
  assign glb_hit  = (slot == GLB_SLOT);
  assign rd_req   = bus_sel & ~bus_wr;
  assign wr_req   = bus_sel & bus_wr;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_strobe
    assign clr_rd[c]   = rd_req & chan_hit & (ch_idx == CH_W'(c)) & (ofs == OFS_Q_PRM);
    assign miss_clr[c] = wr_req & glb_hit & (ofs == GREG_MCLR) & bus_wdata[c];
  end

  always_comb begin
    irq_en_d = irq_en;
    if (wr_req && glb_hit && ofs == GREG_CTRL) irq_en_d = bus_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_en <= 1'b0;
    else        irq_en <= irq_en_d;
  end
endmodule

// File: rtl/accum_rdmux.sv
module accum_rdmux
  import accum_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned ACC_W  = 16,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                                     chan_hit,
  input  logic                                     glb_hit,
  input  logic [CH_W-1:0]                          ch_idx,
  input  logic [SLOT_OFS_W-1:0]                    ofs,
  input  logic [NUM_CH-1:0]                        new_flags,
  input  logic [NUM_CH-1:0]                        miss_flags,
  input  logic                                     irq_en,
  input  logic [NUM_CH-1:0][LANES-1:0][ACC_W-1:0]  acc_all,
  output logic [ACC_W-1:0]                         rd_val
);
  logic [SLOT_OFS_W-1:0] lane_sel;

  assign lane_sel = ofs - 3'd1;

  always_comb begin
    rd_val = '0;
    if (chan_hit) begin
      case (ofs)
        OFS_STAT: rd_val = {{(ACC_W-2){1'b0}}, miss_flags[ch_idx], new_flags[ch_idx]};
        OFS_I_TRK, OFS_Q_TRK, OFS_I_PRM, OFS_Q_PRM:
          rd_val = acc_all[ch_idx][lane_sel[1:0]];
        default: rd_val = '0;
      endcase
    end else if (glb_hit) begin
      case (ofs)
        GREG_NEW:  rd_val[NUM_CH-1:0] = new_flags;
        GREG_MISS: rd_val[NUM_CH-1:0] = miss_flags;
        GREG_CTRL: rd_val[0]          = irq_en;
        default:   rd_val = '0;
      endcase
    end
  end
endmodule

// File: rtl/accum_readout.sv
module accum_readout
  import accum_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned ACC_W  = 16,
  parameter int unsigned ADDR_W = 6,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_CH-1:0]       ch_active,
  input  logic [NUM_CH-1:0]       dump,
  input  logic [NUM_CH*ACC_W-1:0] i_trk_in,
  input  logic [NUM_CH*ACC_W-1:0] q_trk_in,
  input  logic [NUM_CH*ACC_W-1:0] i_prm_in,
  input  logic [NUM_CH*ACC_W-1:0] q_prm_in,
  input  logic                    bus_sel,
  input  logic                    bus_wr,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [ACC_W-1:0]        bus_wdata,
  output logic [ACC_W-1:0]        rd_data,
  output logic                    irq
);
  logic [1:0] rst_pipe;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  logic                                    rd_req, chan_hit, glb_hit, irq_en;
  logic [CH_W-1:0]                         ch_idx;
  logic [SLOT_OFS_W-1:0]                   ofs;
  logic [NUM_CH-1:0]                       clr_rd, miss_clr, new_flags, missed_flags;
  logic [NUM_CH-1:0][LANES-1:0][ACC_W-1:0] acc_all;
  logic [ACC_W-1:0]                        rd_val, rd_data_d;

  accum_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(ACC_W)) u_decode (
    .clk(clk), .rst_n(rst_q), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_req(rd_req),
    .chan_hit(chan_hit), .glb_hit(glb_hit), .ch_idx(ch_idx), .ofs(ofs),
    .clr_rd(clr_rd), .miss_clr(miss_clr), .irq_en(irq_en)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic [LANES-1:0][ACC_W-1:0] lane_in;
    assign lane_in[0] = i_trk_in[c*ACC_W +: ACC_W];
    assign lane_in[1] = q_trk_in[c*ACC_W +: ACC_W];
    assign lane_in[2] = i_prm_in[c*ACC_W +: ACC_W];
    assign lane_in[3] = q_prm_in[c*ACC_W +: ACC_W];

    accum_chan #(.ACC_W(ACC_W)) u_chan (
      .clk(clk), .rst_n(rst_q), .active(ch_active[c]), .dump(dump[c]),
      .lane_in(lane_in), .clr_rd(clr_rd[c]), .miss_clr(miss_clr[c]),
      .new_flag(new_flags[c]), .miss_flag(missed_flags[c]), .lane_q(acc_all[c])
    );
  end

  accum_rdmux #(.NUM_CH(NUM_CH), .ACC_W(ACC_W)) u_rdmux (
    .chan_hit(chan_hit), .glb_hit(glb_hit), .ch_idx(ch_idx), .ofs(ofs),
    .new_flags(new_flags), .miss_flags(missed_flags), .irq_en(irq_en),
    .acc_all(acc_all), .rd_val(rd_val)
  );

  always_comb begin
    rd_data_d = rd_data;
    if (rd_req) rd_data_d = rd_val;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) rd_data <= '0;
    else        rd_data <= rd_data_d;
  end

  assign irq = irq_en & (|new_flags);
endmodule

// File: rtl/accum_readout_chk.sv
module accum_readout_chk #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_q,
  input logic [NUM_CH-1:0] ch_active,
  input logic [NUM_CH-1:0] dump,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [DATA_W-1:0] rd_data,
  input logic              irq,
  input logic [NUM_CH-1:0] new_flags,
  input logic [NUM_CH-1:0] missed_flags,
  input logic [NUM_CH-1:0] clr_rd,
  input logic [NUM_CH-1:0] miss_clr
);
  // R3
  dump_sets_new_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (($past(dump & ch_active) & ~new_flags) == '0));

  // R4
  new_falls_on_clear_chk: assert property (@(posedge clk) disable iff (!rst_q)
    ((~new_flags & $past(new_flags) & ~$past(clr_rd | ~ch_active)) == '0));

  // R5
  missed_needs_dump_chk: assert property (@(posedge clk) disable iff (!rst_q)
    ((missed_flags & ~$past(missed_flags) & ~$past(dump & new_flags)) == '0));

  // R6
  missed_sticky_chk: assert property (@(posedge clk) disable iff (!rst_q)
    ((~missed_flags & $past(missed_flags) & ~$past(miss_clr | ~ch_active)) == '0));

  // R8
  collision_no_miss_chk: assert property (@(posedge clk) disable iff (!rst_q)
    ((missed_flags & ~$past(missed_flags) & $past(clr_rd)) == '0));

  // R9
  irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(irq) |-> ($past(|(dump & ch_active)) || $past(bus_sel && bus_wr)));

  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $past(!(bus_sel && !bus_wr)) |-> $stable(rd_data));
endmodule

bind accum_readout accum_readout_chk #(.NUM_CH(NUM_CH), .DATA_W(ACC_W)) u_chk (
  .clk(clk), .rst_q(rst_q), .ch_active(ch_active), .dump(dump),
  .bus_sel(bus_sel), .bus_wr(bus_wr), .rd_data(rd_data), .irq(irq),
  .new_flags(new_flags), .missed_flags(missed_flags), .clr_rd(clr_rd),
  .miss_clr(miss_clr)
);

// File: tb/accum_readout_bench.sv
module accum_readout_bench;
  localparam int NUM_CH = 4;
  localparam int ACC_W  = 16;
  localparam int ADDR_W = 6;
  localparam int GLB    = NUM_CH * 8;

  logic                    clk = 1'b0;
  logic                    rst_n;
  logic [NUM_CH-1:0]       ch_active, dump;
  logic [NUM_CH*ACC_W-1:0] i_trk_in, q_trk_in, i_prm_in, q_prm_in;
  logic                    bus_sel, bus_wr;
  logic [ADDR_W-1:0]       bus_addr;
  logic [ACC_W-1:0]        bus_wdata, rd_data;
  logic                    irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  accum_readout #(.NUM_CH(NUM_CH), .ACC_W(ACC_W), .ADDR_W(ADDR_W)) u_accum_readout (
    .clk(clk), .rst_n(rst_n), .ch_active(ch_active), .dump(dump),
    .i_trk_in(i_trk_in), .q_trk_in(q_trk_in), .i_prm_in(i_prm_in), .q_prm_in(q_prm_in),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(int addr, output logic [ACC_W-1:0] val);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = ADDR_W'(addr);
    @(negedge clk);
    bus_sel = 0;
    val = rd_data;
  endtask

  task automatic wr(int addr, logic [ACC_W-1:0] val);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = ADDR_W'(addr); bus_wdata = val;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic load(int ch, logic [ACC_W-1:0] it, logic [ACC_W-1:0] qt,
                      logic [ACC_W-1:0] ip, logic [ACC_W-1:0] qp);
    i_trk_in[ch*ACC_W +: ACC_W] = it;
    q_trk_in[ch*ACC_W +: ACC_W] = qt;
    i_prm_in[ch*ACC_W +: ACC_W] = ip;
    q_prm_in[ch*ACC_W +: ACC_W] = qp;
  endtask

  task automatic do_dump(int ch, logic [ACC_W-1:0] it, logic [ACC_W-1:0] qt,
                         logic [ACC_W-1:0] ip, logic [ACC_W-1:0] qp);
    @(negedge clk);
    load(ch, it, qt, ip, qp);
    dump[ch] = 1'b1;
    @(negedge clk);
    dump = '0;
  endtask

  task automatic t_reset();
    logic [ACC_W-1:0] v;
    chk("R1 rd_data", 32'(rd_data), 0);
    chk("R1 irq", 32'(irq), 0);
    rd(0, v);         chk("R1 ch0 status", 32'(v), 0);
    rd(GLB + 0, v);   chk("R1 new summary", 32'(v), 0);
    rd(GLB + 2, v);   chk("R1 irq enable", 32'(v), 0);
  endtask

  task automatic t_capture();
    logic [ACC_W-1:0] v;
    wr(GLB + 2, 16'h1);
    do_dump(1, 16'h1234, 16'hFF80, 16'h7FFF, 16'h8001);
    chk("R9 irq after dump", 32'(irq), 1);
    rd(8 + 0, v);   chk("R3 status new", 32'(v), 1);
    rd(GLB + 0, v); chk("R3 summary bit", 32'(v), 32'h2);
    rd(8 + 1, v);   chk("R2 i_trk", 32'(v), 32'h1234);
    rd(8 + 2, v);   chk("R2 q_trk", 32'(v), 32'hFF80);
    rd(8 + 3, v);   chk("R2 i_prm", 32'(v), 32'h7FFF);
    rd(8 + 0, v);   chk("R4 other reads keep new", 32'(v), 1);
    rd(8 + 4, v);   chk("R2 q_prm", 32'(v), 32'h8001);
    rd(8 + 0, v);   chk("R4 q_prm read clears new", 32'(v), 0);
    chk("R9 irq drops", 32'(irq), 0);
    repeat (3) @(negedge clk);
    chk("R11 rd_data holds", 32'(rd_data), 0);
  endtask

  task automatic t_overrun();
    logic [ACC_W-1:0] v;
    do_dump(2, 16'h0001, 16'h0002, 16'h0003, 16'h0004);
    do_dump(2, 16'h0011, 16'h0012, 16'h0013, 16'h0014);
    rd(16 + 0, v);  chk("R5 status new+missed", 32'(v), 3);
    rd(GLB + 1, v); chk("R5 missed summary", 32'(v), 32'h4);
    rd(16 + 1, v);  chk("R5 overwrite i_trk", 32'(v), 32'h0011);
    rd(16 + 4, v);  chk("R5 overwrite q_prm", 32'(v), 32'h0014);
    rd(16 + 0, v);  chk("R6 missed survives read", 32'(v), 2);
    wr(GLB + 3, 16'h0B);
    rd(16 + 0, v);  chk("R6 other bits no clear", 32'(v), 2);
    wr(GLB + 3, 16'h04);
    rd(16 + 0, v);  chk("R6 clear write", 32'(v), 0);
    do_dump(2, 16'h0, 16'h0, 16'h0, 16'h5);
    @(negedge clk);
    load(2, 16'h0, 16'h0, 16'h0, 16'h6);
    dump[2] = 1; bus_sel = 1; bus_wr = 1; bus_addr = ADDR_W'(GLB + 3); bus_wdata = 16'h4;
    @(negedge clk);
    dump = '0; bus_sel = 0; bus_wr = 0;
    rd(16 + 0, v);  chk("R6 set beats clear", 32'(v), 3);
    rd(16 + 4, v);
    wr(GLB + 3, 16'h4);
  endtask

  task automatic t_collision();
    logic [ACC_W-1:0] v;
    do_dump(3, 16'h0A0A, 16'h0B0B, 16'h0C0C, 16'h0D0D);
    @(negedge clk);
    load(3, 16'h1A1A, 16'h1B1B, 16'h1C1C, 16'h1D1D);
    dump[3] = 1; bus_sel = 1; bus_wr = 0; bus_addr = ADDR_W'(24 + 4);
    @(negedge clk);
    dump = '0; bus_sel = 0;
    chk("R8 read returns pre-dump value", 32'(rd_data), 32'h0D0D);
    rd(24 + 0, v);  chk("R8 new stays, no missed", 32'(v), 1);
    rd(24 + 4, v);  chk("R8 newer value kept", 32'(v), 32'h1D1D);
    rd(24 + 0, v);  chk("R8 cleared afterwards", 32'(v), 0);
  endtask

  task automatic t_inactive();
    logic [ACC_W-1:0] v;
    do_dump(0, 16'h0100, 16'h0200, 16'h0300, 16'h0400);
    do_dump(0, 16'h0101, 16'h0201, 16'h0301, 16'h0401);
    @(negedge clk); ch_active[0] = 0;
    rd(0, v);       chk("R7 flags cleared", 32'(v), 0);
    do_dump(0, 16'hDEAD, 16'hBEEF, 16'hCAFE, 16'hF00D);
    rd(0, v);       chk("R7 dump ignored flags", 32'(v), 0);
    rd(1, v);       chk("R7 dump ignored data", 32'(v), 32'h0101);
    chk("R9 irq stays low", 32'(irq), 0);
    @(negedge clk); ch_active[0] = 1;
  endtask

  task automatic t_irq_mask();
    logic [ACC_W-1:0] v;
    wr(GLB + 2, 16'h0);
    do_dump(1, 16'h1, 16'h2, 16'h3, 16'h4);
    chk("R9 masked irq", 32'(irq), 0);
    wr(GLB + 2, 16'h1);
    chk("R9 enable raises irq", 32'(irq), 1);
    rd(GLB + 2, v); chk("R9 enable readback", 32'(v), 1);
    rd(8 + 4, v);
    chk("R9 irq off after consume", 32'(irq), 0);
  endtask

  task automatic t_undef();
    logic [ACC_W-1:0] v;
    do_dump(0, 16'h5555, 16'h6666, 16'h7777, 16'h8888);
    rd(5, v);       chk("R10 ch slot ofs5", 32'(v), 0);
    rd(7, v);       chk("R10 ch slot ofs7", 32'(v), 0);
    rd(GLB + 3, v); chk("R10 clear port reads 0", 32'(v), 0);
    rd(GLB + 4, v); chk("R10 global ofs4", 32'(v), 0);
    wr(1, 16'h0000);
    wr(0, 16'h0000);
    wr(GLB + 5, 16'hFFFF);
    wr(GLB + 0, 16'h0000);
    rd(1, v);       chk("R10 acc not writable", 32'(v), 32'h5555);
    rd(0, v);       chk("R10 status not writable", 32'(v), 1);
    rd(GLB + 2, v); chk("R10 ctrl untouched", 32'(v), 1);
    rd(4, v);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ch_active = '1; dump = '0;
    i_trk_in = '0; q_trk_in = '0; i_prm_in = '0; q_prm_in = '0;
    bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_capture();
    t_overrun();
    t_collision();
    t_inactive();
    t_irq_mask();
    t_undef();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule